// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block watches a key matrix built from four scan outputs and five return inputs. A pressed key shorts one scan line to one return line. The return lines idle high through pull-ups and are active low. While nothing is happening, every scan line is held low, so any press pulls at least one return line low. After the return lines have been synchronised and have held a new value for a programmable debounce time, the block starts a search. The search drives one scan line low at a time, from index 0 upward. The first column that shows a low return line, together with the lowest low row in that column, identifies the key.

Two matrix positions are wired to nothing. A hit on either of them is dropped silently. A hit on any other position loads a key code, raises a valid flag, and raises an interrupt that stays high until software acknowledges it. After a report, the block reports nothing new until every key has been released and that release has been debounced. Only the first key found is reported, with no rollover beyond it.

Top module: `kpd_scanner`

## Requirements
- R1: During and right after reset, scan_n is 4'b0000, irq is 0, key_valid is 0 and key_code is 0.
- R2: While idle, all four scan_n bits are low. During a search, exactly one scan_n bit is low at a time. No other scan_n pattern ever appears.
- R3: Return inputs are synchronised and debounced. A press that lasts fewer than DEBOUNCE_CYC cycles is never reported. No report appears earlier than DEBOUNCE_CYC cycles after a press begins.
- R4: The key code is row*4 + column. The row is the ret_n bit index (0..4) and the column is the scan_n bit index (0..3). The resulting codes are: Send 1, End 2, Soft-left 4, Up 5, Down 6, Soft-right 7, keys 1/4/7/* 8..11, keys 2/5/8/0 12..15, keys 3/6/9/# 16..19.
- R5: Positions row 0 column 0 (code 0) and row 0 column 3 (code 3) are unconnected. A hit there leaves irq at 0 and key_valid at 0, and key_code keeps its previous value.
- R6: After a report, irq stays high until irq_ack is sampled high. irq is low from the next cycle on.
- R7: key_valid rises together with a report and falls once the release of all keys has been debounced. key_code stays constant while key_valid is high.
- R8: While any key is still held after a report, a further press produces no new report and does not change key_code.
- R9: When several keys are pressed together, the key with the lowest column index is reported, and among those the one with the lowest row index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_n | output | 4 | Scan line drive, active low |
| ret_n | input | 5 | Return line sense, active low, pulled up |
| key_code | output | 5 | Code of the last reported key |
| key_valid | output | 1 | Reported key is still held |
| irq | output | 1 | Key interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
A scan state machine that loses its column index shows at the ports within one search. The wrong line goes low on scan_n, or a wrong key_code is loaded a few cycles after the debounce time ends. A debounce counter that is reset wrongly or saturates wrongly shows up in one of two ways. A short glitch raises irq, or a press or release arrives early or late against the DEBOUNCE_CYC window. A release detector stuck in the wrong state either holds key_valid high after all keys are up, or lets a second press overwrite key_code while the first key is still held. Each of these is observable within a few hundred cycles of the stimulus.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   typedef enum logic [1:0] {
      KS_IDLE   = 2'd0,
      KS_SEARCH = 2'd1,
      KS_DRAIN  = 2'd2
   } kpd_state_e;
endpackage

// File: rtl/kpd_rtn_filter.sv
module kpd_rtn_filter #(
   parameter int W       = 5,
   parameter int DEB_CYC = 20000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_n,
   input  logic         hold,
   output logic [W-1:0] sync_n,
   output logic [W-1:0] stable_n
);
   localparam int CW = $clog2(DEB_CYC + 1);

   logic [W-1:0]  meta_q, sync_q, cand_q, stab_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '1;
         sync_q <= '1;
         cand_q <= '1;
         stab_q <= '1;
         cnt_q  <= '0;
      end else begin
         meta_q <= raw_n;
         sync_q <= meta_q;
         cand_q <= sync_q;
         if (hold || sync_q != cand_q || sync_q == stab_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(DEB_CYC - 1)) begin
            stab_q <= sync_q;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sync_n   = sync_q;
   assign stable_n = stab_q;
endmodule

// File: rtl/kpd_first_low.sv
module kpd_first_low #(
   parameter int W  = 5,
   parameter int IW = 3
) (
   input  logic [W-1:0]  vec_n,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (!vec_n[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/kpd_key_map.sv
module kpd_key_map #(
   parameter int NS     = 4,
   parameter int NR     = 5,
   parameter int RW     = 3,
   parameter int CLW    = 2,
   parameter int CODE_W = 5,
   parameter logic [NR*NS-1:0] NC_MASK = 'h9
) (
   input  logic [RW-1:0]     row,
   input  logic [CLW-1:0]    col,
   output logic [CODE_W-1:0] code,
   output logic              connected
);
   generate
      if ((1 << CLW) == NS) begin : g_concat
         assign code = CODE_W'({row, col});
      end else begin : g_mult
         assign code = CODE_W'(row) * CODE_W'(NS) + CODE_W'(col);
      end
   endgenerate

   assign connected = !NC_MASK[code];
endmodule

// File: rtl/kpd_scan_ctrl.sv
module kpd_scan_ctrl
   import kpd_pkg::*;
#(
   parameter int NS        = 4,
   parameter int NR        = 5,
   parameter int RW        = 3,
   parameter int CLW       = 2,
   parameter int SETTLE    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NR-1:0]  stable_n,
   input  logic [NR-1:0]  sync_n,
   output logic [NS-1:0]  scan_n,
   output logic           hold,
   output logic           hit,
   output logic [RW-1:0]  hit_row,
   output logic [CLW-1:0] hit_col,
   output logic           released
);
   localparam int SW = $clog2(SETTLE + 1);

   kpd_state_e     state_q;
   logic [CLW-1:0] col_q;
   logic [SW-1:0]  wait_q;
   logic           row_found;
   logic [RW-1:0]  row_idx;

   kpd_first_low #(.W(NR), .IW(RW)) u_row (
      .vec_n (sync_n),
      .found (row_found),
      .idx   (row_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= KS_IDLE;
         col_q    <= '0;
         wait_q   <= '0;
         hit      <= 1'b0;
         hit_row  <= '0;
         hit_col  <= '0;
         released <= 1'b0;
      end else begin
         hit      <= 1'b0;
         released <= 1'b0;
         unique case (state_q)
            KS_IDLE: begin
               if (!(&stable_n)) begin
                  state_q <= KS_SEARCH;
                  col_q   <= '0;
                  wait_q  <= '0;
               end
            end
            KS_SEARCH: begin
               if (wait_q == SW'(SETTLE - 1)) begin
                  wait_q <= '0;
                  if (row_found) begin
                     hit     <= 1'b1;
                     hit_row <= row_idx;
                     hit_col <= col_q;
                     state_q <= KS_DRAIN;
                  end else if (col_q == CLW'(NS - 1)) begin
                     state_q <= KS_DRAIN;
                  end else begin
                     col_q <= col_q + 1'b1;
                  end
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            KS_DRAIN: begin
               if (&stable_n) begin
                  state_q  <= KS_IDLE;
                  released <= 1'b1;
               end
            end
            default: state_q <= KS_IDLE;
         endcase
      end
   end

   always_comb begin
      scan_n = '0;
      if (state_q == KS_SEARCH) begin
         scan_n        = '1;
         scan_n[col_q] = 1'b0;
      end
   end

   assign hold = (state_q == KS_SEARCH);
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
   parameter int NUM_SCAN     = 4,
   parameter int NUM_RET      = 5,
   parameter int DEBOUNCE_CYC = 20000,
   parameter int SETTLE_CYC   = 3,
   parameter logic [NUM_RET*NUM_SCAN-1:0] NC_MASK = 'h9,
   localparam int RW          = $clog2(NUM_RET),
   localparam int CLW         = $clog2(NUM_SCAN),
   localparam int CODE_W      = $clog2(NUM_RET * NUM_SCAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_SCAN-1:0] scan_n,
   input  logic [NUM_RET-1:0]  ret_n,
   output logic [CODE_W-1:0]   key_code,
   output logic                key_valid,
   output logic                irq,
   input  logic                irq_ack
);
   generate
      if (NUM_SCAN < 2 || NUM_RET < 2) begin : g_bad_dims
         $error("kpd_scanner: matrix needs at least two scan and two return lines");
      end
      if (DEBOUNCE_CYC < 4) begin : g_bad_deb
         $error("kpd_scanner: DEBOUNCE_CYC must be at least 4");
      end
      if (SETTLE_CYC < 3) begin : g_bad_settle
         $error("kpd_scanner: SETTLE_CYC must cover the two-flop synchroniser");
      end
   endgenerate

   logic [NUM_RET-1:0] sync_n, stable_n;
   logic               hold, hit, released, connected;
   logic [RW-1:0]      hit_row;
   logic [CLW-1:0]     hit_col;
   logic [CODE_W-1:0]  code;

   kpd_rtn_filter #(.W(NUM_RET), .DEB_CYC(DEBOUNCE_CYC)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_n    (ret_n),
      .hold     (hold),
      .sync_n   (sync_n),
      .stable_n (stable_n)
   );

   kpd_scan_ctrl #(
      .NS(NUM_SCAN), .NR(NUM_RET), .RW(RW), .CLW(CLW), .SETTLE(SETTLE_CYC)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .stable_n (stable_n),
      .sync_n   (sync_n),
      .scan_n   (scan_n),
      .hold     (hold),
      .hit      (hit),
      .hit_row  (hit_row),
      .hit_col  (hit_col),
      .released (released)
   );

   kpd_key_map #(
      .NS(NUM_SCAN), .NR(NUM_RET), .RW(RW), .CLW(CLW),
      .CODE_W(CODE_W), .NC_MASK(NC_MASK)
   ) u_map (
      .row       (hit_row),
      .col       (hit_col),
      .code      (code),
      .connected (connected)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_code  <= '0;
         key_valid <= 1'b0;
         irq       <= 1'b0;
      end else if (hit && connected) begin
         key_code  <= code;
         key_valid <= 1'b1;
         irq       <= 1'b1;
      end else begin
         if (irq_ack)  irq       <= 1'b0;
         if (released) key_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk #(
   parameter int NUM_SCAN = 4,
   parameter int NUM_RET  = 5,
   parameter int CODE_W   = 5,
   parameter logic [NUM_RET*NUM_SCAN-1:0] NC_MASK = 'h9
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SCAN-1:0] scan_n,
   input logic [CODE_W-1:0]   key_code,
   input logic                key_valid,
   input logic                irq,
   input logic                irq_ack
);
   localparam int FULL = 1 << CODE_W;
   localparam logic [FULL-1:0] NC_FULL = FULL'(NC_MASK);

   p_scan_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~scan_n) == NUM_SCAN) || ($countones(~scan_n) == 1));

   p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (!irq || $rose(key_valid)));

   p_code_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> $stable(key_code));

   p_no_nc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> (int'(key_code) < NUM_RET * NUM_SCAN) && !NC_FULL[key_code]);

   p_irq_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> key_valid);
endmodule

bind kpd_scanner kpd_scanner_chk #(
   .NUM_SCAN(NUM_SCAN), .NUM_RET(NUM_RET), .CODE_W(CODE_W), .NC_MASK(NC_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_n    (scan_n),
   .key_code  (key_code),
   .key_valid (key_valid),
   .irq       (irq),
   .irq_ack   (irq_ack)
);

// File: tb/kpd_scanner_test.sv
`timescale 1ns/1ps
module kpd_scanner_test;
   localparam int DEB = 8;
   localparam int LIM = 150;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] scan_n;
   logic [4:0] ret_n;
   logic [4:0] key_code;
   logic       key_valid, irq;
   logic       irq_ack = 1'b0;
   logic       pressed [5][4];

   int n_cmp = 0;
   int n_bad = 0;
   int bad_scan = 0;
   bit saw_single = 1'b0;
   int prev_code = 0;

   always #2.5 clk = ~clk;

   kpd_scanner #(.DEBOUNCE_CYC(DEB), .SETTLE_CYC(3)) uut (
      .clk(clk), .rst_n(rst_n), .scan_n(scan_n), .ret_n(ret_n),
      .key_code(key_code), .key_valid(key_valid), .irq(irq), .irq_ack(irq_ack)
   );

   always_comb begin
      for (int r = 0; r < 5; r++) begin
         ret_n[r] = 1'b1;
         for (int c = 0; c < 4; c++)
            if (pressed[r][c] && !scan_n[c]) ret_n[r] = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones(~scan_n) == 1) saw_single = 1'b1;
         else if ($countones(~scan_n) != 4) bad_scan++;
      end
   end

   // row[10:8] col[7:6] reported[5] code[4:0]
   localparam logic [10:0] VEC [20] = '{
      {3'd0, 2'd1, 1'b1, 5'd1},  {3'd0, 2'd2, 1'b1, 5'd2},
      {3'd0, 2'd0, 1'b0, 5'd0},  {3'd0, 2'd3, 1'b0, 5'd3},
      {3'd1, 2'd0, 1'b1, 5'd4},  {3'd1, 2'd1, 1'b1, 5'd5},
      {3'd1, 2'd2, 1'b1, 5'd6},  {3'd1, 2'd3, 1'b1, 5'd7},
      {3'd2, 2'd0, 1'b1, 5'd8},  {3'd2, 2'd1, 1'b1, 5'd9},
      {3'd2, 2'd2, 1'b1, 5'd10}, {3'd2, 2'd3, 1'b1, 5'd11},
      {3'd3, 2'd0, 1'b1, 5'd12}, {3'd3, 2'd1, 1'b1, 5'd13},
      {3'd3, 2'd2, 1'b1, 5'd14}, {3'd3, 2'd3, 1'b1, 5'd15},
      {3'd4, 2'd0, 1'b1, 5'd16}, {3'd4, 2'd1, 1'b1, 5'd17},
      {3'd4, 2'd2, 1'b1, 5'd18}, {3'd4, 2'd3, 1'b1, 5'd19}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic release_all();
      for (int r = 0; r < 5; r++)
         for (int c = 0; c < 4; c++) pressed[r][c] = 1'b0;
   endtask

   // waits for irq; returns cycles taken, or -1 on timeout
   task automatic wait_irq(output int took);
      took = -1;
      for (int k = 1; k <= LIM; k++) begin
         cyc(1);
         if (irq) begin took = k; break; end
      end
   endtask

   task automatic wait_unvalid(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < LIM; k++) begin
         cyc(1);
         if (!key_valid) begin ok = 1'b1; break; end
      end
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      cyc(1);
      irq_ack = 1'b0;
   endtask

   initial begin
      #(150000 * 5);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
   end

   initial begin
      int took;
      bit ok;
      release_all();
      cyc(4);
      // R1: values held under reset
      chk(scan_n == 4'b0000, "R1 scan_n in reset", scan_n, 0);
      chk(!irq && !key_valid && key_code == 0, "R1 outputs in reset",
          {irq, key_valid, key_code}, 0);
      rst_n = 1'b1;
      cyc(3);
      chk(scan_n == 4'b0000, "R2 idle scan all low", scan_n, 0);
      chk(!irq && !key_valid && key_code == 0, "R1 outputs after reset",
          {irq, key_valid, key_code}, 0);

      // R3: glitch shorter than debounce
      pressed[2][0] = 1'b1;
      cyc(DEB / 2);
      pressed[2][0] = 1'b0;
      cyc(60);
      chk(!irq && !key_valid, "R3 short glitch ignored", {irq, key_valid}, 0);

      // Vector walk: R4, R5, R6, R7, R3 latency
      for (int i = 0; i < 20; i++) begin
         automatic int row  = int'(VEC[i][10:8]);
         automatic int col  = int'(VEC[i][7:6]);
         automatic bit rep  = VEC[i][5];
         automatic int code = int'(VEC[i][4:0]);
         pressed[row][col] = 1'b1;
         if (rep) begin
            wait_irq(took);
            chk(took >= DEB, "R3 report not before debounce", took, DEB);
            chk(key_code == code, "R4 key code", key_code, code);
            chk(key_valid, "R7 valid with report", key_valid, 1);
            cyc(20);
            chk(irq, "R6 irq held without ack", irq, 1);
            ack();
            chk(!irq, "R6 irq cleared by ack", irq, 0);
            chk(key_valid && key_code == code, "R7 code held while key down",
                key_code, code);
            prev_code = code;
            release_all();
            wait_unvalid(ok);
            chk(ok, "R7 valid drops after release", key_valid, 0);
            chk(key_code == code, "R7 code kept after release", key_code, code);
            cyc(5);
         end else begin
            cyc(LIM);
            chk(!irq && !key_valid, "R5 unconnected hit ignored",
                {irq, key_valid}, 0);
            chk(key_code == prev_code, "R5 code unchanged", key_code, prev_code);
            release_all();
            cyc(DEB + 20);
         end
      end

      // R6: irq survives key release until acked
      pressed[1][1] = 1'b1;
      wait_irq(took);
      chk(took > 0 && key_code == 5, "R4 Up key code", key_code, 5);
      release_all();
      wait_unvalid(ok);
      cyc(10);
      chk(irq, "R6 irq held after release", irq, 1);
      ack();
      chk(!irq, "R6 irq cleared after ack", irq, 0);

      // R8: second press while first held
      pressed[3][1] = 1'b1;
      wait_irq(took);
      chk(key_code == 13, "R8 first key code", key_code, 13);
      ack();
      pressed[1][0] = 1'b1;
      cyc(LIM);
      chk(!irq, "R8 no report while held", irq, 0);
      chk(key_code == 13 && key_valid, "R8 code unchanged", key_code, 13);
      pressed[3][1] = 1'b0;
      cyc(60);
      chk(!irq && key_code == 13, "R8 partial release no report", key_code, 13);
      release_all();
      wait_unvalid(ok);
      chk(ok, "R8 valid drops after full release", key_valid, 0);
      cyc(30);

      // R9: simultaneous keys
      pressed[4][2] = 1'b1;
      pressed[2][3] = 1'b1;
      pressed[3][2] = 1'b1;
      wait_irq(took);
      chk(took > 0 && key_code == 14, "R9 lowest column then row", key_code, 14);
      ack();
      release_all();
      wait_unvalid(ok);
      cyc(30);

      // R5: unconnected position next to a connected one in column 3
      pressed[0][3] = 1'b1;
      pressed[1][3] = 1'b1;
      cyc(LIM);
      chk(!irq && key_code == 14, "R5 first hit unconnected dropped", key_code, 14);
      release_all();
      cyc(DEB + 20);

      chk(bad_scan == 0, "R2 scan pattern", bad_scan, 0);
      chk(saw_single, "R2 single line search seen", saw_single, 1);
      summary();
      $finish;
   end
endmodule